// File: doc/BRIEF.md
# System Tick Timer

A periodic down-counting timer for a processor subsystem. Software programs a 24-bit reload value, picks the count source and enables the counter. On each count step the counter decrements. A step taken at zero loads the reload value, so one full period is reload + 1 steps. Each time the count falls from 1 to 0, the block sets a sticky wrap flag. If the interrupt enable is set, it also pulses a tick request toward the interrupt controller.

Four 32-bit registers sit on a simple synchronous bus. Reads are combinational and writes take effect at the clock edge. The wrap flag clears when the control/status register is read. Any write to the count register zeroes the count. A read-only calibration word gives the reload value for a 10 ms period and two qualifier bits, all set by parameters. The count source is either the processor clock or the rising edges of a slower reference input. The reference input is synchronized inside the block.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control/status, reload and count registers read as zero and tick_irq_o is low.
- R2: Register word offsets are 0x0 control/status, 0x4 reload, 0x8 count, 0xC calibration (address bits [3:2]). Control/status fields: bit 0 count enable, bit 1 interrupt enable, bit 2 source select, bit 16 wrap flag. All other bits read as zero.
- R3: With source select = 1, the counter steps on every processor clock. The interval between wraps is reload + 1 cycles.
- R4: The wrap flag sets when the count steps from 1 to 0. A read of control/status returns it and then clears it. A write to control/status leaves it unchanged.
- R5: The reload and count fields occupy bits [23:0]. Bits [31:24] read as zero and are ignored on write.
- R6: A write of any data to the count register sets the count to zero and clears the wrap flag.
- R7: With source select = 0, the counter steps once per rising edge of ref_tick_i, after two synchronizer flops. A rising edge driven before clock edge k updates the count at edge k+2. A level held high gives no further steps.
- R8: tick_irq_o is high for exactly one cycle, the cycle after each 1-to-0 step, and only when the interrupt enable is set.
- R9: With a reload value of zero, an enabled counter stays at zero and never sets the wrap flag or requests an interrupt.
- R10: The calibration word holds NOREF in bit 31, SKEW in bit 30 and TENMS in bits [23:0], taken from parameters. Writes to it have no effect.
- R11: With count enable clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Asynchronous slow reference input |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| tick_irq_o | output | 1 | One-cycle tick interrupt request |

## Verification
Read data is combinational, so the bench samples it one time step after the falling edge that presents a read. A write reaches the registers at the next rising edge. With the processor clock as source, enable takes effect at the edge of the enabling write. The first step loads the reload value one edge later, and tick_irq_o rises after reload + 1 edges. The bench counts falling edges from the write to the pulse and between pulses. For the reference source, the count is read two and three clock edges after the input rises. The bench expects no change at two edges and the new value at three. Flag checks run with the counter stopped, so that no step can race a clearing read.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_RELOAD = 2'd1;
  localparam logic [1:0] IDX_COUNT = 2'd2;
  localparam logic [1:0] IDX_CALIB = 2'd3;
  localparam int unsigned BIT_EN = 0;
  localparam int unsigned BIT_IE = 1;
  localparam int unsigned BIT_SRC = 2;
  localparam int unsigned BIT_FLAG = 16;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cnt_clr_i,
  input  logic             flag_rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic flag_q, irq_q, wrap;

  assign wrap = step_i & (cnt_q == ONE) & ~cnt_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= wrap & irq_en_i;
      if (cnt_clr_i) cnt_q <= '0;
      else if (step_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - ONE;
      // set wins over read-clear in the same cycle
      if (cnt_clr_i) flag_q <= 1'b0;
      else if (wrap) flag_q <= 1'b1;
      else if (flag_rd_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_q == '0 && !flag_q)); // R6
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q == ONE && !cnt_clr_i) |=> (flag_q && cnt_q == '0)); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R8
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i)); // R8
  AST_ZERO_RELOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q == '0 && reload_i == '0 && !cnt_clr_i) |=> (cnt_q == '0 && !irq_o)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !cnt_clr_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        CAL_NOREF   = 1'b0,
  parameter logic        CAL_SKEW    = 1'b1,
  parameter logic [23:0] CAL_TENMS   = 24'd499999
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_tick_i,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        tick_irq_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic [1:0] idx;
  logic wr, rd;
  logic en_q, ie_q, src_q;
  logic [CNT_W-1:0] reload_q, cnt;
  logic ref_rise, step, flag;
  logic [DATA_W-1:0] calib;
  logic unused_bits;

  assign idx = bus_addr_i[3:2];
  assign wr  = bus_sel_i & bus_we_i;
  assign rd  = bus_sel_i & ~bus_we_i;
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[DATA_W-1:CNT_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      src_q    <= 1'b0;
      reload_q <= '0;
    end else if (wr) begin
      if (idx == IDX_CTRL) begin
        en_q  <= bus_wdata_i[BIT_EN];
        ie_q  <= bus_wdata_i[BIT_IE];
        src_q <= bus_wdata_i[BIT_SRC];
      end
      if (idx == IDX_RELOAD) reload_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  tick_ref_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_tick_i),
    .rise_o (ref_rise)
  );

  assign step = en_q & (src_q | ref_rise);

  tick_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .irq_en_i  (ie_q),
    .reload_i  (reload_q),
    .cnt_clr_i (wr && idx == IDX_COUNT),
    .flag_rd_i (rd && idx == IDX_CTRL),
    .cnt_o     (cnt),
    .flag_o    (flag),
    .irq_o     (tick_irq_o)
  );

  assign calib = {CAL_NOREF, CAL_SKEW, {(DATA_W-26){1'b0}}, CAL_TENMS};

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (idx)
        IDX_CTRL: begin
          bus_rdata_o[BIT_EN]   = en_q;
          bus_rdata_o[BIT_IE]   = ie_q;
          bus_rdata_o[BIT_SRC]  = src_q;
          bus_rdata_o[BIT_FLAG] = flag;
        end
        IDX_RELOAD: bus_rdata_o = {{PAD_W{1'b0}}, reload_q};
        IDX_COUNT:  bus_rdata_o = {{PAD_W{1'b0}}, cnt};
        default:    bus_rdata_o = calib;
      endcase
    end
  end

  AST_RELOAD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == IDX_RELOAD) |=> (reload_q == $past(bus_wdata_i[CNT_W-1:0]))); // R5
  AST_CTRL_WRITE_KEEPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == IDX_CTRL && flag) |=> flag); // R4
endmodule

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;
  localparam logic [31:0] A_CTRL = 32'h0, A_REL = 32'h4, A_CNT = 32'h8, A_CAL = 32'hC;
  localparam logic [31:0] CAL_EXP = 32'h4007_A11F; // SKEW=1, NOREF=0, TENMS=499999

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  sys_tick_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns at the next falling edge
  task automatic wr_reg(input logic [31:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a[3:0]; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_reg(input logic [31:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a[3:0];
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic expect_reg(input logic [31:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd_reg(a, v);
    chk(v === exp, req, v, exp);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int cyc, irqs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq === 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
    expect_reg(A_CTRL, 32'h0, "R1 ctrl");
    expect_reg(A_REL, 32'h0, "R1 reload");
    expect_reg(A_CNT, 32'h0, "R1 count");

    // R10 calibration word, writes ignored
    expect_reg(A_CAL, CAL_EXP, "R10 calib");
    wr_reg(A_CAL, 32'h0);
    expect_reg(A_CAL, CAL_EXP, "R10 calib after write");

    // R2 control layout: only bits 0..2 writable, bit 16 flag not writable
    wr_reg(A_CTRL, 32'hFFFF_FFFE);
    expect_reg(A_CTRL, 32'h0000_0006, "R2 ctrl fields");
    wr_reg(A_CTRL, 32'h0);

    // R5 upper bits ignored
    wr_reg(A_REL, 32'hFFFF_FFFF);
    expect_reg(A_REL, 32'h00FF_FFFF, "R5 reload width");
    wr_reg(A_CTRL, 32'h5);   // enable, processor clock
    wr_reg(A_CTRL, 32'h0);   // one step taken: loads reload
    expect_reg(A_CNT, 32'h00FF_FFFF, "R5 count width");
    // R11 hold while disabled
    repeat (5) @(negedge clk);
    expect_reg(A_CNT, 32'h00FF_FFFF, "R11 hold disabled");

    // R3/R8 period sweep on processor clock
    for (int r = 1; r <= 8; r++) begin
      wr_reg(A_CTRL, 32'h0);
      wr_reg(A_REL, r);
      wr_reg(A_CNT, 32'hDEAD_BEEF);
      wr_reg(A_CTRL, 32'h7);
      cyc = 0;
      while (!irq && cyc < 100) begin @(negedge clk); cyc++; end
      chk(cyc == r + 1, "R3 first wrap latency", cyc, r + 1);
      @(negedge clk);
      chk(irq === 1'b0, "R8 pulse width", {31'b0, irq}, 32'h0);
      cyc = 1;
      while (!irq && cyc < 100) begin @(negedge clk); cyc++; end
      chk(cyc == r + 1, "R3 period", cyc, r + 1);
    end
    wr_reg(A_CTRL, 32'h0);

    // R8 no irq with interrupt enable clear; flag still sets (R4)
    wr_reg(A_REL, 32'd2);
    wr_reg(A_CNT, 32'h0);
    expect_reg(A_CTRL, 32'h0, "R6 flag cleared by count write");
    wr_reg(A_CTRL, 32'h5);
    irqs = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (irq) irqs++; end
    wr_reg(A_CTRL, 32'h0);
    chk(irqs == 0, "R8 irq masked", irqs, 0);
    // R4 write to ctrl kept the flag; read returns then clears it
    expect_reg(A_CTRL, 32'h0001_0000, "R4 flag set and kept on ctrl write");
    expect_reg(A_CTRL, 32'h0, "R4 flag cleared by read");

    // R6 count write clears count and flag
    wr_reg(A_CTRL, 32'h5);
    repeat (6) @(negedge clk);
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_CNT, 32'h1234_5678);
    expect_reg(A_CNT, 32'h0, "R6 count zeroed");
    expect_reg(A_CTRL, 32'h0, "R6 flag cleared");

    // R9 zero reload
    wr_reg(A_REL, 32'h0);
    wr_reg(A_CTRL, 32'h7);
    irqs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (irq) irqs++; end
    chk(irqs == 0, "R9 no irq", irqs, 0);
    expect_reg(A_CNT, 32'h0, "R9 count stays zero");
    wr_reg(A_CTRL, 32'h0);
    expect_reg(A_CTRL, 32'h0, "R9 no flag");

    // R7 reference source, reload 3
    wr_reg(A_REL, 32'd3);
    wr_reg(A_CNT, 32'h0);
    wr_reg(A_CTRL, 32'h3);   // enable, irq enable, reference source
    repeat (4) @(negedge clk);
    expect_reg(A_CNT, 32'h0, "R7 no step without edge");
    ref_tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_reg(A_CNT, 32'h0, "R7 two edges after rise");
    expect_reg(A_CNT, 32'd3, "R7 three edges after rise");
    repeat (6) @(negedge clk);
    expect_reg(A_CNT, 32'd3, "R7 level gives no step");
    irqs = 0;
    for (int e = 0; e < 3; e++) begin
      ref_tick = 1'b0;
      repeat (4) @(negedge clk);
      ref_tick = 1'b1;
      for (int i = 0; i < 5; i++) begin @(negedge clk); if (irq) irqs++; end
      expect_reg(A_CNT, 32'(2 - e), "R7 edge step");
    end
    chk(irqs == 1, "R8 irq on reference wrap", irqs, 1);
    wr_reg(A_CTRL, 32'h2);
    expect_reg(A_CTRL, 32'h0001_0002, "R4 flag after reference wrap");
    expect_reg(A_CTRL, 32'h0000_0002, "R4 flag read-cleared");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule